// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA open-drain data) that gives a host read and write access to a 256-byte register file. SCL and SDA are sampled with a fast system clock through two-flop synchronizers. Bus edges, START and STOP conditions are detected on the synchronized copies. A bit-level state machine matches the 7-bit slave address, takes a sub-address byte and then moves data bytes. The sub-address steps by one after every data byte.

The slave address is 0x46 or 0x47, chosen by the `dev_sel` pin. A write sends the sub-address and then any number of data bytes. A read first writes the sub-address, then issues a repeated START with the read bit set, and the slave returns bytes until the master answers with a NACK. The slave only ever pulls SDA low or releases it. Neighbouring logic reads the stored settings through a separate combinational read port. Clock stretching and 10-bit addressing are not supported.

Top module: `twi_reg_slave`

## Requirements
- R1: The 7-bit slave address is 0x46 when `dev_sel`=0 and 0x47 when `dev_sel`=1. A matching address byte is acknowledged: SDA is pulled low during the ninth SCL pulse.
- R2: An address byte that does not match is not acknowledged. The slave then ignores the bus until the next START, so any bytes that follow change no register.
- R3: In a write (address with bit0=0), the first byte after the address is the sub-address. Each following data byte is stored at the current sub-address, and every byte is acknowledged.
- R4: The sub-address increments by one after each data byte, whether read or written, and wraps from 0xFF to 0x00.
- R5: After a sub-address write and a repeated START with the address and bit0=1, the slave returns bytes MSB first, starting at the sub-address. It returns one more byte after each master ACK, stops after a master NACK, and leaves SDA released.
- R6: SDA is only pulled low or released. The pull-down changes only while SCL is low.
- R7: A STOP or START inside a data byte ends the transfer. The partial byte is discarded and bytes written earlier are kept. After a START the slave expects an address byte.
- R8: While `rst_n` is low, SDA is released, every register reads 0, and bus activity is not acknowledged and writes nothing.
- R9: `cfg_data` always shows the register selected by `cfg_addr`, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset; the interface is held off while low |
| dev_sel | input | 1 | Selects slave address 0x46 (0) or 0x47 (1) |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_low | output | 1 | When 1 the pad pulls SDA low; when 0 SDA is released |
| cfg_addr | input | 8 | Register index for the on-chip read port |
| cfg_data | output | 8 | Contents of the register at `cfg_addr` |

## Verification
A wrong state or phase inside the protocol engine shows first on the acknowledge slot. If the engine is off by one bit, the ninth-pulse ACK is missing or lands on a data bit, and the master sees this within one byte time. A wrong sub-address pointer does not disturb the bus handshake. It shows only as data landing in the wrong register, or read back from the wrong one. This is caught either on the next read byte or at once on the `cfg_data` port. The tests therefore compare every acknowledge bit, every byte read, and the neighbours of each register touched, including the 0xFF-to-0x00 wrap and bytes cut short by START or STOP.

// File: rtl/twi_slave_pkg.sv
package twi_slave_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_TX_ACK
    } twi_state_e;

    typedef enum logic [1:0] {
        RX_ADDR,
        RX_SUB,
        RX_DATA
    } rx_kind_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_pipe_d, scl_pipe_q;
    logic [LAST:0] sda_pipe_d, sda_pipe_q;
    logic          scl_last_d, scl_last_q;
    logic          sda_last_d, sda_last_q;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[LAST-1:0], scl_i};
        sda_pipe_d = {sda_pipe_q[LAST-1:0], sda_i};
        scl_last_d = scl_pipe_q[LAST];
        sda_last_d = sda_pipe_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_last_q <= 1'b1;
            sda_last_q <= 1'b1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
            scl_last_q <= scl_last_d;
            sda_last_q <= sda_last_d;
        end
    end

    assign scl_s     = scl_pipe_q[LAST];
    assign sda_s     = sda_pipe_q[LAST];
    assign scl_rise  = scl_s & ~scl_last_q;
    assign scl_fall  = ~scl_s & scl_last_q;
    assign start_evt = scl_s & scl_last_q & ~sda_s & sda_last_q;
    assign stop_evt  = scl_s & scl_last_q & sda_s & ~sda_last_q;
endmodule

// File: rtl/twi_proto_fsm.sv
module twi_proto_fsm
    import twi_slave_pkg::*;
#(
    parameter int          PTR_W         = 8,
    parameter logic [5:0]  SLAVE_ADDR_HI = 6'h23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_sel,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [PTR_W-1:0]  ptr,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_pull_low
);
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        twi_state_e        st;
        rx_kind_e          kind;
        logic              rd_mode;
        logic              nack;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [PTR_W-1:0]  ptr;
        logic              drv;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      wr_en_d;
    logic [6:0] own_addr;

    assign own_addr = {SLAVE_ADDR_HI, dev_sel};

    always_comb begin
        r_d     = r_q;
        wr_en_d = 1'b0;
        if (start_evt) begin
            r_d.st   = ST_RX;
            r_d.kind = RX_ADDR;
            r_d.cnt  = '0;
            r_d.drv  = 1'b0;
        end else if (stop_evt) begin
            r_d.st  = ST_IDLE;
            r_d.drv = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: ;
                ST_RX: begin
                    if (scl_rise && r_q.cnt < FULL_BYTE) begin
                        r_d.shreg = {r_q.shreg[BYTE_W-2:0], sda_s};
                        r_d.cnt   = r_q.cnt + CNT_W'(1);
                    end else if (scl_fall && r_q.cnt == FULL_BYTE) begin
                        unique case (r_q.kind)
                            RX_ADDR: begin
                                if (r_q.shreg[BYTE_W-1:1] == own_addr) begin
                                    r_d.rd_mode = r_q.shreg[0];
                                    r_d.drv     = 1'b1;
                                    r_d.st      = ST_ACK;
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end
                            RX_SUB: begin
                                r_d.ptr = r_q.shreg[PTR_W-1:0];
                                r_d.drv = 1'b1;
                                r_d.st  = ST_ACK;
                            end
                            default: begin
                                wr_en_d = 1'b1;
                                r_d.ptr = r_q.ptr + PTR_W'(1);
                                r_d.drv = 1'b1;
                                r_d.st  = ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.kind == RX_ADDR && r_q.rd_mode) begin
                            r_d.shreg = rd_data;
                            r_d.ptr   = r_q.ptr + PTR_W'(1);
                            r_d.drv   = ~rd_data[BYTE_W-1];
                            r_d.st    = ST_TX;
                        end else begin
                            r_d.drv  = 1'b0;
                            r_d.st   = ST_RX;
                            r_d.kind = (r_q.kind == RX_ADDR) ? RX_SUB : RX_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == LAST_BIT) begin
                            r_d.drv = 1'b0;
                            r_d.cnt = '0;
                            r_d.st  = ST_TX_ACK;
                        end else begin
                            r_d.cnt   = r_q.cnt + CNT_W'(1);
                            r_d.shreg = {r_q.shreg[BYTE_W-2:0], 1'b0};
                            r_d.drv   = ~r_q.shreg[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        r_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (!r_q.nack) begin
                            r_d.shreg = rd_data;
                            r_d.ptr   = r_q.ptr + PTR_W'(1);
                            r_d.drv   = ~rd_data[BYTE_W-1];
                            r_d.cnt   = '0;
                            r_d.st    = ST_TX;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, kind: RX_ADDR, rd_mode: 1'b0, nack: 1'b1,
                     cnt: '0, shreg: '0, ptr: '0, drv: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ptr          = r_q.ptr;
    assign wr_en        = wr_en_d;
    assign wr_data      = r_q.shreg;
    assign sda_pull_low = r_q.drv;

    // R6: the pull-down only moves while the synchronized clock line is low
    p_drive_moves_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.drv) |-> !scl_s);

    // R4: every stored byte advances the pointer by one, with wrap
    p_ptr_step_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (r_q.ptr == $past(r_q.ptr) + PTR_W'(1)));

    // R2: an idle slave never holds SDA low
    p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !r_q.drv);

    // R3: the bit counter never passes a whole byte
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt <= FULL_BYTE);
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data,
    input  logic [AW-1:0] cfg_addr,
    output logic [DW-1:0] cfg_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign bus_data = mem_q[bus_addr];
    assign cfg_data = mem_q[cfg_addr];

    // R3: a write strobe lands its byte at the addressed entry
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave
    import twi_slave_pkg::*;
#(
    parameter int         REG_AW        = 8,
    parameter int         SYNC_STAGES   = 2,
    parameter logic [5:0] SLAVE_ADDR_HI = 6'h23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_sel,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_low,
    input  logic [REG_AW-1:0] cfg_addr,
    output logic [BYTE_W-1:0] cfg_data
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              wr_en;
    logic [REG_AW-1:0] ptr;
    logic [BYTE_W-1:0] wr_data, bus_data;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    twi_proto_fsm #(.PTR_W(REG_AW), .SLAVE_ADDR_HI(SLAVE_ADDR_HI)) fsm_i (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt), .rd_data(bus_data),
        .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data), .sda_pull_low(sda_pull_low)
    );

    twi_reg_bank #(.AW(REG_AW), .DW(BYTE_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
        .bus_addr(ptr), .bus_data(bus_data), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
    );

    // R8: no pull-down while held in reset
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_released_r8: assert (!sda_pull_low);
        end
    end
endmodule

// File: tb/twi_reg_slave_tb_top.sv
module twi_reg_slave_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dev_sel = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [7:0] cfg_addr = 8'h00;
    logic [7:0] cfg_data;
    logic       drv;
    logic       sda_bus;

    assign sda_bus = sda_m & ~drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    twi_reg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_pull_low(drv), .cfg_addr(cfg_addr), .cfg_data(cfg_data)
    );

    int         checks = 0;
    int         errors = 0;
    int         r6_viol = 0;
    logic [7:0] model [256];
    logic [7:0] exp_q [$];
    logic [7:0] act_q [$];
    string      tag_q [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: pops scoreboard items as the read bytes arrive
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(a == e, t, a, e);
            end
        end
    end

    // R6 observer: the pull-down must not move while SCL is high
    logic drv_prev = 1'b0;
    always @(negedge clk) begin
        if (drv !== drv_prev && scl_m) r6_viol++;
        drv_prev <= drv;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    task automatic qwait;
        repeat (QTR) @(posedge clk);
        #1;
    endtask

    task automatic bus_start;
        sda_m = 1'b1; scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_rstart;
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qwait();
        scl_m = 1'b1; qwait();
        qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        b = sda_bus; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic x;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(x);
        acked = !x;
    endtask

    task automatic get_byte(input bit master_ack, output logic [7:0] v);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(x);
            v[i] = x;
        end
        send_bit(!master_ack);
    endtask

    task automatic write_seq(input logic [6:0] a7, input logic [7:0] sub,
                             input logic [7:0] d [4], input int n,
                             input bit exp_ack, input string req);
        bit ack;
        bus_start();
        send_byte({a7, 1'b0}, ack);
        check(ack == exp_ack, {req, " address ack"}, ack, exp_ack);
        send_byte(sub, ack);
        check(ack == exp_ack, {req, " sub-address ack"}, ack, exp_ack);
        for (int i = 0; i < n; i++) begin
            send_byte(d[i], ack);
            check(ack == exp_ack, {req, " data ack"}, ack, exp_ack);
            if (exp_ack) model[8'(sub + 8'(i))] = d[i];
        end
        bus_stop();
    endtask

    task automatic read_seq(input logic [6:0] a7, input logic [7:0] sub,
                            input int n, input string req);
        bit ack;
        logic [7:0] v;
        bus_start();
        send_byte({a7, 1'b0}, ack);
        check(ack, {req, " address ack"}, ack, 1);
        send_byte(sub, ack);
        check(ack, {req, " sub-address ack"}, ack, 1);
        bus_rstart();
        send_byte({a7, 1'b1}, ack);
        check(ack, {req, " read address ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(model[8'(sub + 8'(i))]);
            tag_q.push_back({req, " read byte"});
            get_byte(i < n - 1, v);
            act_q.push_back(v);
        end
        check(drv == 1'b0, {req, " SDA released after NACK"}, drv, 0);
        bus_stop();
    endtask

    task automatic cfg_chk(input logic [7:0] a, input logic [7:0] e, input string req);
        cfg_addr = a;
        #1;
        check(cfg_data == e, req, cfg_data, e);
    endtask

    initial begin
        bit ack;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (5) @(posedge clk);
        #1;
        // R8: reset state
        check(drv == 1'b0, "R8 no pull-down in reset", drv, 0);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        cfg_chk(8'h00, 8'h00, "R8 register 0x00 cleared");
        cfg_chk(8'hFF, 8'h00, "R8 register 0xFF cleared");

        // R1 R3 R4 R9: basic write at 0x46
        dev_sel = 1'b0;
        write_seq(7'h46, 8'h10, '{8'hA1, 8'hB2, 8'hC3, 8'h00}, 3, 1'b1, "R1 R3");
        cfg_chk(8'h10, 8'hA1, "R3 R9 first byte stored");
        cfg_chk(8'h11, 8'hB2, "R4 second byte at next index");
        cfg_chk(8'h12, 8'hC3, "R4 third byte at next index");
        cfg_chk(8'h13, 8'h00, "R4 neighbour untouched");

        // R2: wrong address is ignored
        write_seq(7'h47, 8'h10, '{8'hEE, 8'hEE, 8'h00, 8'h00}, 2, 1'b0, "R2 mismatch");
        cfg_chk(8'h10, 8'hA1, "R2 register unchanged after mismatch");
        cfg_chk(8'h11, 8'hB2, "R2 register unchanged after mismatch");

        // R1: dev_sel=1 moves the address to 0x47
        dev_sel = 1'b1;
        bus_start();
        send_byte({7'h46, 1'b0}, ack);
        check(!ack, "R1 0x46 not acked with dev_sel=1", ack, 0);
        bus_stop();
        // R4: wrap from 0xFF to 0x00
        write_seq(7'h47, 8'hFE, '{8'h11, 8'h22, 8'h33, 8'h00}, 3, 1'b1, "R1 R4 wrap");
        cfg_chk(8'hFE, 8'h11, "R4 byte at 0xFE");
        cfg_chk(8'hFF, 8'h22, "R4 byte at 0xFF");
        cfg_chk(8'h00, 8'h33, "R4 byte wrapped to 0x00");

        // R5: reads with repeated START
        read_seq(7'h47, 8'h10, 3, "R5");
        read_seq(7'h47, 8'hFF, 2, "R4 R5 read wrap");
        read_seq(7'h47, 8'h13, 1, "R5 single byte");

        // R7: STOP inside a data byte
        write_seq(7'h47, 8'h20, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1, 1'b1, "R7 setup");
        bus_start();
        send_byte({7'h47, 1'b0}, ack);
        send_byte(8'h21, ack);
        send_byte(8'h6B, ack);
        check(ack, "R7 full byte acked", ack, 1);
        model[8'h21] = 8'h6B;
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        cfg_chk(8'h20, 8'h5A, "R7 earlier byte kept");
        cfg_chk(8'h21, 8'h6B, "R7 last full byte kept");
        cfg_chk(8'h22, 8'h00, "R7 partial byte dropped on STOP");

        // R7: START inside a data byte, then address phase
        bus_start();
        send_byte({7'h47, 1'b0}, ack);
        send_byte(8'h30, ack);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        bus_rstart();
        send_byte({7'h47, 1'b0}, ack);
        check(ack, "R7 address accepted after mid-byte START", ack, 1);
        bus_stop();
        cfg_chk(8'h30, 8'h00, "R7 partial byte dropped on START");
        read_seq(7'h47, 8'h20, 2, "R7 R5 read back");

        // R8: reset clears and blocks the bus
        rst_n = 1'b0;
        #1;
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        cfg_chk(8'h10, 8'h00, "R8 reset clears register");
        write_seq(7'h47, 8'h40, '{8'h77, 8'h00, 8'h00, 8'h00}, 1, 1'b0, "R8 bus in reset");
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        cfg_chk(8'h40, 8'h00, "R8 nothing written during reset");
        write_seq(7'h47, 8'h40, '{8'h99, 8'h00, 8'h00, 8'h00}, 1, 1'b1, "R8 bus after reset");
        cfg_chk(8'h40, 8'h99, "R8 write works after release");

        // R6: pull-down never moved with SCL high
        check(r6_viol == 0, "R6 drive change while SCL high", r6_viol, 0);

        repeat (20) @(posedge clk);
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule